// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block drives a character LCD panel with an 8-bit parallel bus. When reset is released it works through a fixed list of fifteen items. The first eight are commands: four function-set writes that select 8-bit bus, two lines and a 5x8 font; display off; clear; display on with the cursor hidden; and an entry mode that moves the cursor right after each write. The last seven are the ASCII bytes of the word WELCOME. The panel latches each byte on the falling edge of the enable strobe. The block holds enable high for a parameterised number of cycles, drops it, and then waits before it starts the next item.

Two waiting strategies are chosen at elaboration time. The timed variant waits a uniform gap of `STEP_CYCLES` clocks after every item. The default is 210000 clocks, or 4.2 ms at 50 MHz. The polling variant reads the panel's busy flag (bus bit 7) with read/write high and register-select low. It repeats that read until the flag is clear. When the list is exhausted the block parks with enable low and raises `done` until the next reset.

The bus is split into an output byte, a drive enable and an input byte. An external pad or tristate buffer joins them. The drive enable is active exactly when read/write is low.

Top module: `lcd_bootseq`

## Requirements
- R1: While `rst` is high, the outputs are `lcd_dout`=0x38, `lcd_doe`=1, `lcd_rs`=0, `lcd_rw`=0, `lcd_en`=1 and `done`=0.
- R2: The bytes latched on the successive falling edges of `lcd_en` with `lcd_rw`=0 are, in order: 0x38, 0x38, 0x38, 0x38, 0x08, 0x01, 0x0C, 0x06, 0x57, 0x45, 0x4C, 0x43, 0x4F, 0x4D, 0x45. Nothing else is latched.
- R3: `lcd_rs` is 0 when each of the first eight items is latched and 1 when each of the seven characters is latched.
- R4: Every write holds `lcd_en` high for exactly `EN_HIGH_CYCLES`+1 clocks. `lcd_dout` and `lcd_rs` stay unchanged while it is high.
- R5: In the timed variant (`BUSY_POLL`=0), `lcd_en` stays low for exactly `STEP_CYCLES` clocks between consecutive writes. The block never sets `lcd_rw`, and `lcd_din` has no effect on it.
- R6: `lcd_doe` is 1 exactly when `lcd_rw` is 0.
- R7: In the polling variant (`BUSY_POLL`=1), each status read has `lcd_rw`=1, `lcd_rs`=0 and `lcd_doe`=0. It holds `lcd_en` high for exactly `EN_HIGH_CYCLES` clocks, and `lcd_din[7]` is sampled at the end of the high phase.
- R8: In the polling variant, no write starts while the most recent status read returned bit 7 = 1. A write follows as soon as a read returns 0.
- R9: After the fifteenth item, `done` goes high. It stays high with `lcd_en` and `lcd_rw` low, and no further strobes occur until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_din | input | 8 | Panel data bus as read back from the pads |
| lcd_dout | output | 8 | Byte driven toward the panel |
| lcd_doe | output | 1 | Drive enable for `lcd_dout`; low means the bus is high impedance |
| lcd_rs | output | 1 | Register select: 0 command, 1 character data |
| lcd_rw | output | 1 | Read/write: 1 for a status read |
| lcd_en | output | 1 | Enable strobe; the panel latches on its falling edge |
| done | output | 1 | High once the whole list has been written |

## Verification
The bench builds two copies with the gap shrunk to 40 clocks and the strobe width to 3 clocks. This lets the full fifteen-item run, and the idle state after it, be checked in a few hundred cycles instead of millions. One copy uses the timed variant with `lcd_din` held at 0xFF, so an input that would read as "busy" forever must be ignored. The other uses the polling variant against a panel model that stays busy for 10 clocks after each latch. That forces several status reads per item and exposes any write issued too early.

// File: rtl/lcd_bootseq_pkg.sv
package lcd_bootseq_pkg;

   localparam int unsigned SEQ_LEN = 15;
   localparam int unsigned IDX_W   = $clog2(SEQ_LEN + 1);

   typedef enum logic [2:0] {
      ST_PULSE,
      ST_TOGGLE,
      ST_HOLD,
      ST_POLL_START,
      ST_POLL_HI,
      ST_POLL_LO,
      ST_IDLE
   } seq_state_t;

   typedef struct packed {
      logic       rs;
      logic [7:0] code;
   } seq_item_t;

   function automatic seq_item_t item_at(input logic [IDX_W-1:0] i);
      seq_item_t it;
      case (i)
         4'd0, 4'd1, 4'd2, 4'd3: it = '{rs: 1'b0, code: 8'h38};
         4'd4:  it = '{rs: 1'b0, code: 8'h08};
         4'd5:  it = '{rs: 1'b0, code: 8'h01};
         4'd6:  it = '{rs: 1'b0, code: 8'h0C};
         4'd7:  it = '{rs: 1'b0, code: 8'h06};
         4'd8:  it = '{rs: 1'b1, code: 8'h57};
         4'd9:  it = '{rs: 1'b1, code: 8'h45};
         4'd10: it = '{rs: 1'b1, code: 8'h4C};
         4'd11: it = '{rs: 1'b1, code: 8'h43};
         4'd12: it = '{rs: 1'b1, code: 8'h4F};
         4'd13: it = '{rs: 1'b1, code: 8'h4D};
         4'd14: it = '{rs: 1'b1, code: 8'h45};
         default: it = '{rs: 1'b0, code: 8'h00};
      endcase
      return it;
   endfunction

endpackage

// File: rtl/lcd_bootseq_rom.sv
module lcd_bootseq_rom
   import lcd_bootseq_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       code,
   output logic             rs
);
   seq_item_t it;

   always_comb begin
      it   = item_at(idx);
      code = it.code;
      rs   = it.rs;
   end
endmodule

// File: rtl/lcd_bootseq_ctr.sv
module lcd_bootseq_ctr #(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt;

   assign hit = (cnt == limit - 1'b1);

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (hit)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
      cnt < limit)
      else $error("interval counter passed its limit");
endmodule

// File: rtl/lcd_bootseq.sv
module lcd_bootseq
   import lcd_bootseq_pkg::*;
#(
   parameter int unsigned STEP_CYCLES    = 210000,
   parameter int unsigned EN_HIGH_CYCLES = 50,
   parameter bit          BUSY_POLL      = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] lcd_din,
   output logic [7:0] lcd_dout,
   output logic       lcd_doe,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic       lcd_en,
   output logic       done
);
   localparam int unsigned MAXC = (STEP_CYCLES > EN_HIGH_CYCLES) ? STEP_CYCLES : EN_HIGH_CYCLES;
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

   if (EN_HIGH_CYCLES < 1) begin : g_bad_en
      $error("EN_HIGH_CYCLES must be at least 1");
   end
   if (STEP_CYCLES < 2) begin : g_bad_step
      $error("STEP_CYCLES must be at least 2");
   end

   seq_state_t       st;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] idx_nxt;
   logic [7:0]       nxt_code;
   logic             nxt_rs;
   logic [7:0]       first_code;
   logic             first_rs;
   logic [CW-1:0]    lim;
   logic             hit;
   logic             ctr_clr;
   logic             bsy;

   assign idx_nxt = idx + 1'b1;

   lcd_bootseq_rom u_rom_next (.idx(idx_nxt), .code(nxt_code), .rs(nxt_rs));
   lcd_bootseq_rom u_rom_first (.idx('0), .code(first_code), .rs(first_rs));

   assign lim     = (st == ST_HOLD) ? CW'(STEP_CYCLES) : CW'(EN_HIGH_CYCLES);
   assign ctr_clr = (st == ST_TOGGLE) || (st == ST_POLL_START) || (st == ST_IDLE);

   lcd_bootseq_ctr #(.W(CW)) u_ctr (
      .clk(clk), .rst(rst), .clr(ctr_clr), .limit(lim), .hit(hit)
   );

   if (BUSY_POLL) begin : g_poll
      logic unused_low;
      assign unused_low = ^lcd_din[6:0];
      always_ff @(posedge clk) begin
         if (rst)
            bsy <= 1'b0;
         else if (st == ST_POLL_HI && hit)
            bsy <= lcd_din[7];
      end
   end else begin : g_timed
      logic unused_din;
      assign unused_din = ^lcd_din;
      assign bsy = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_PULSE;
         idx      <= '0;
         lcd_dout <= first_code;
         lcd_rs   <= first_rs;
         lcd_rw   <= 1'b0;
         lcd_en   <= 1'b1;
         done     <= 1'b0;
      end else begin
         unique case (st)
            ST_PULSE: begin
               if (hit) st <= ST_TOGGLE;
            end
            ST_TOGGLE: begin
               lcd_en <= 1'b0;
               st     <= BUSY_POLL ? ST_POLL_START : ST_HOLD;
            end
            ST_POLL_START: begin
               lcd_rw <= 1'b1;
               lcd_rs <= 1'b0;
               lcd_en <= 1'b1;
               st     <= ST_POLL_HI;
            end
            ST_POLL_HI: begin
               if (hit) begin
                  lcd_en <= 1'b0;
                  st     <= ST_POLL_LO;
               end
            end
            ST_HOLD, ST_POLL_LO: begin
               if (hit) begin
                  if (st == ST_POLL_LO && bsy) begin
                     lcd_en <= 1'b1;
                     st     <= ST_POLL_HI;
                  end else if (idx == LAST) begin
                     lcd_rw <= 1'b0;
                     done   <= 1'b1;
                     st     <= ST_IDLE;
                  end else begin
                     idx      <= idx_nxt;
                     lcd_dout <= nxt_code;
                     lcd_rs   <= nxt_rs;
                     lcd_rw   <= 1'b0;
                     lcd_en   <= 1'b1;
                     st       <= ST_PULSE;
                  end
               end
            end
            ST_IDLE: begin
               lcd_en <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign lcd_doe = ~lcd_rw;

   assert_write_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (lcd_en && $past(lcd_en) && !lcd_rw) |-> ($stable(lcd_dout) && $stable(lcd_rs)))
      else $error("write data moved while enable high");

   assert_read_is_status_R7: assert property (@(posedge clk) disable iff (rst)
      lcd_rw |-> !lcd_rs)
      else $error("status read with register select high");

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> done)
      else $error("done dropped");

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (done && $past(done)) |-> (!lcd_en && !lcd_rw))
      else $error("activity after done");

   if (!BUSY_POLL) begin : g_timed_chk
      assert_timed_no_read_R5: assert property (@(posedge clk) disable iff (rst)
         !lcd_rw)
         else $error("timed variant issued a read");
   end
endmodule

// File: tb/sim_lcd_bootseq.sv
`timescale 1ns/1ps
module sim_lcd_bootseq;
   localparam int STEP = 40;
   localparam int ENH  = 3;
   localparam int BUSY_N = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic [7:0] d0, d1, din1;
   logic oe0, rs0, rw0, en0, done0;
   logic oe1, rs1, rw1, en1, done1;
   int busy1 = 0;
   assign din1 = {(busy1 != 0), 7'h2A};

   lcd_bootseq #(.STEP_CYCLES(STEP), .EN_HIGH_CYCLES(ENH), .BUSY_POLL(1'b0)) u0 (
      .clk(clk), .rst(rst), .lcd_din(8'hFF), .lcd_dout(d0), .lcd_doe(oe0),
      .lcd_rs(rs0), .lcd_rw(rw0), .lcd_en(en0), .done(done0));

   lcd_bootseq #(.STEP_CYCLES(STEP), .EN_HIGH_CYCLES(ENH), .BUSY_POLL(1'b1)) u1 (
      .clk(clk), .rst(rst), .lcd_din(din1), .lcd_dout(d1), .lcd_doe(oe1),
      .lcd_rs(rs1), .lcd_rw(rw1), .lcd_en(en1), .done(done1));

   int n_run = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_item(input int i);
      case (i)
         0, 1, 2, 3: return {1'b0, 8'h38};
         4: return {1'b0, 8'h08};
         5: return {1'b0, 8'h01};
         6: return {1'b0, 8'h0C};
         7: return {1'b0, 8'h06};
         8: return {1'b1, 8'h57};
         9: return {1'b1, 8'h45};
         10: return {1'b1, 8'h4C};
         11: return {1'b1, 8'h43};
         12: return {1'b1, 8'h4F};
         13: return {1'b1, 8'h4D};
         default: return {1'b1, 8'h45};
      endcase
   endfunction

   // monitor of the timed copy
   logic [8:0] wlog0 [16];
   int nw0 = 0, hi0 = 0, lo0 = 0, hibad0 = 0, gapbad0 = 0, rd0 = 0, oebad0 = 0;
   logic pen0 = 1'b0, prs0 = 1'b0, prw0 = 1'b0;
   logic [7:0] pd0 = '0;
   always @(negedge clk) begin
      if (rst) begin
         nw0 = 0; hi0 = 0; lo0 = 0;
      end else begin
         if (oe0 !== ~rw0) oebad0++;
         if (en0) begin
            if (!pen0) begin
               if (nw0 > 0 && lo0 != STEP) gapbad0++;
               lo0 = 0;
            end
            hi0++;
         end else begin
            if (pen0) begin
               if (!prw0) begin
                  if (nw0 < 16) wlog0[nw0] = {prs0, pd0};
                  if (nw0 > 0 && hi0 != ENH + 1) hibad0++;
                  nw0++;
               end else rd0++;
               hi0 = 0;
            end
            lo0++;
         end
      end
      pen0 = en0; pd0 = d0; prs0 = rs0; prw0 = rw0;
   end

   // monitor of the polling copy and busy panel model
   logic [8:0] wlog1 [16];
   int nw1 = 0, hi1 = 0, rd1 = 0, rdbad1 = 0, rdviol1 = 0, wbusy1 = 0, oebad1 = 0;
   logic pen1 = 1'b0, prs1 = 1'b0, prw1 = 1'b0;
   logic [7:0] pd1 = '0;
   always @(negedge clk) begin
      if (rst) begin
         nw1 = 0; hi1 = 0; busy1 = 0;
      end else begin
         if (oe1 !== ~rw1) oebad1++;
         if (rw1 && (rs1 || oe1)) rdviol1++;
         if (busy1 > 0) busy1--;
         if (en1) hi1++;
         else if (pen1) begin
            if (!prw1) begin
               if (nw1 < 16) wlog1[nw1] = {prs1, pd1};
               if (busy1 != 0) wbusy1++;
               busy1 = BUSY_N;
               nw1++;
            end else begin
               rd1++;
               if (hi1 != ENH) rdbad1++;
            end
            hi1 = 0;
         end
      end
      pen1 = en1; pd1 = d1; prs1 = rs1; prw1 = rw1;
   end

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(en0 === 1'b1, "R1 en", en0, 1);
      chk(d0 === 8'h38, "R1 data", d0, 8'h38);
      chk(rs0 === 1'b0 && rw0 === 1'b0, "R1 rs/rw", {rs0, rw0}, 0);
      chk(oe0 === 1'b1, "R6 drive in reset", oe0, 1);
      chk(done0 === 1'b0 && done1 === 1'b0, "R1 done", {done0, done1}, 0);
   endtask

   task automatic t_timed_run;
      int t = 0;
      while (done0 !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
      chk(done0 === 1'b1, "R9 timed done", done0, 1);
      chk(nw0 == 15, "R2 timed write count", nw0, 15);
      for (int i = 0; i < 15; i++) begin
         chk(wlog0[i][7:0] == exp_item(i)[7:0], "R2 timed byte", wlog0[i][7:0], exp_item(i)[7:0]);
         chk(wlog0[i][8] == exp_item(i)[8], "R3 timed rs", wlog0[i][8], exp_item(i)[8]);
      end
      chk(hibad0 == 0, "R4 enable width", hibad0, 0);
      chk(gapbad0 == 0, "R5 step gap", gapbad0, 0);
      chk(rd0 == 0, "R5 no reads with busy input high", rd0, 0);
      chk(oebad0 == 0, "R6 drive matches rw", oebad0, 0);
   endtask

   task automatic t_idle;
      repeat (100) @(negedge clk);
      chk(nw0 == 15, "R9 no strobe after done", nw0, 15);
      chk(en0 === 1'b0 && rw0 === 1'b0, "R9 idle lines", {en0, rw0}, 0);
      chk(done0 === 1'b1, "R9 done held", done0, 1);
   endtask

   task automatic t_poll_run;
      int t = 0;
      while (done1 !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
      chk(done1 === 1'b1, "R9 poll done", done1, 1);
      chk(nw1 == 15, "R2 poll write count", nw1, 15);
      for (int i = 0; i < 15; i++) begin
         chk(wlog1[i] == exp_item(i), "R2 R3 poll item", wlog1[i], exp_item(i));
      end
      chk(wbusy1 == 0, "R8 write while busy", wbusy1, 0);
      chk(rd1 >= 30, "R8 repeated reads while busy", rd1, 30);
      chk(rdbad1 == 0, "R7 read strobe width", rdbad1, 0);
      chk(rdviol1 == 0, "R7 read rs/drive", rdviol1, 0);
      chk(oebad1 == 0, "R6 poll drive matches rw", oebad1, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      @(negedge clk) rst = 1'b0;
      t_timed_run();
      t_idle();
      t_poll_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule